// File: doc/BRIEF.md
# Sixteen-bit Register-File Operate Unit

This block carries out the arithmetic and logic class of a small 16-bit load/store processor. It holds eight 16-bit general registers and a three-flag condition-code register. It accepts one instruction word per cycle over a valid/ready input. The word is decoded into an add, an and or a complement. The unit reads one or two source registers, or one register and a sign-extended 5-bit constant, then writes the result back and records whether the result was negative, zero or positive.

The instruction input never applies back-pressure in normal operation. `instr_ready` is high in every cycle outside reset, so a word is consumed on each clock edge where `instr_valid` is high. During reset `instr_ready` is low, and words offered then are dropped. A combinational debug read port shows the contents of any register. The flags appear as a 3-bit vector `{neg, zero, pos}`. Memory, branching and program-counter logic are handled elsewhere.

Instruction layout: opcode in [15:12], destination in [11:9], first source in [8:6], mode in [5]. When mode is 0 the second source register is in [2:0]. When mode is 1 the 5-bit signed constant is in [4:0]. The opcodes are add = 4'b0001, and = 4'b0101, complement = 4'b1001.

Top module: `opunit_top`

## Requirements
- R1: A synchronous reset clears all eight registers to 16'h0000 and sets the flags to 3'b010 (zero only).
- R2: Add with bit [5] = 0 writes src1 + src2 modulo 2^16 into the destination register.
- R3: Add with bit [5] = 1 writes src1 plus the sign-extended constant in [4:0] modulo 2^16.
- R4: And writes src1 & operand into the destination, where the operand is src2 or the sign-extended constant, selected by bit [5] as for add.
- R5: Complement (bits [5:0] all ones) writes ~src1 into the destination. The result is correct when the destination and source are the same register.
- R6: After every register write the flags hold exactly one set bit: bit 2 if result[15] is 1, bit 1 if the result is zero, bit 0 otherwise.
- R7: A word whose opcode is not one of the three, or a complement whose bits [5:0] are not all ones, leaves every register and the flags unchanged.
- R8: A cycle with `instr_valid` low leaves every register and the flags unchanged.
- R9: A write lands at the accepting clock edge and is visible on the debug port and to the next instruction in the following cycle, so back-to-back dependent instructions see the new value.
- R10: `instr_ready` is 0 while reset is high and 1 otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| instr_valid | input | 1 | Instruction word present |
| instr_ready | output | 1 | Unit can take a word this cycle |
| instr_word | input | 16 | Encoded instruction |
| dbg_sel | input | 3 | Register index for the debug read port |
| dbg_data | output | 16 | Contents of the selected register |
| cc_flags | output | 3 | Condition flags {neg, zero, pos} |

## Verification
The hardest state to reach from the ports is a register holding a large value at the signed boundary, such as 16'h7FFF or 16'h8000. Such values are needed to show that add wraps and that the negative flag follows bit 15. The constant is only five bits wide, so no single word can load them. The directed part builds them by repeatedly doubling a register that holds one, then complementing it. The seeded random part then mixes in register aliasing, malformed complement words and idle cycles, and after each word it compares every register and the flags against a bench model.

// File: rtl/opunit_pkg.sv
package opunit_pkg;
  localparam int DATA_W  = 16;
  localparam int NREG    = 8;
  localparam int REG_AW  = $clog2(NREG);
  localparam int IMM_W   = 5;
  localparam int OPC_W   = 4;

  typedef enum logic [OPC_W-1:0] {
    OPC_ADD = 4'b0001,
    OPC_AND = 4'b0101,
    OPC_NOT = 4'b1001
  } opc_e;

  typedef enum logic [1:0] {
    ALU_ADD = 2'd0,
    ALU_AND = 2'd1,
    ALU_NOT = 2'd2
  } alu_op_e;

  typedef struct packed {
    logic              legal;
    alu_op_e           op;
    logic              use_imm;
    logic [REG_AW-1:0] dst;
    logic [REG_AW-1:0] src1;
    logic [REG_AW-1:0] src2;
    logic [DATA_W-1:0] imm;
  } dec_t;

  typedef struct packed {
    logic neg;
    logic zero;
    logic pos;
  } cc_t;
endpackage

// File: rtl/opunit_decode.sv
module opunit_decode
  import opunit_pkg::*;
(
  input  logic [15:0] word,
  input  logic        valid,
  output dec_t        dec
);
  localparam int EXT_W = DATA_W - IMM_W;

  logic [OPC_W-1:0] opc;
  logic             not_form_ok;

  assign opc         = word[15:12];
  assign not_form_ok = (word[5:0] == 6'b111111);

  always_comb begin
    dec.dst     = word[11:9];
    dec.src1    = word[8:6];
    dec.src2    = word[2:0];
    dec.use_imm = word[5];
    dec.imm     = {{EXT_W{word[IMM_W-1]}}, word[IMM_W-1:0]};
    dec.op      = ALU_ADD;
    dec.legal   = 1'b0;
    unique case (opc)
      OPC_ADD: begin dec.op = ALU_ADD; dec.legal = valid; end
      OPC_AND: begin dec.op = ALU_AND; dec.legal = valid; end
      OPC_NOT: begin dec.op = ALU_NOT; dec.legal = valid & not_form_ok; end
      default: begin dec.op = ALU_ADD; dec.legal = 1'b0; end
    endcase
  end
endmodule

// File: rtl/opunit_regfile.sv
module opunit_regfile
  import opunit_pkg::*;
#(
  parameter int W = DATA_W,
  parameter int N = NREG,
  localparam int AW = $clog2(N)
)(
  input  logic          clk,
  input  logic          rst,
  input  logic [AW-1:0] ra_addr,
  output logic [W-1:0]  ra_data,
  input  logic [AW-1:0] rb_addr,
  output logic [W-1:0]  rb_data,
  input  logic [AW-1:0] rd_addr,
  output logic [W-1:0]  rd_data,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [W-1:0]  wdata
);
  logic [W-1:0]   mem_q [N];
  logic [N*W-1:0] flat;

  for (genvar i = 0; i < N; i++) begin : g_reg
    always_ff @(posedge clk) begin
      if (rst)                   mem_q[i] <= '0;
      else if (we && waddr == i) mem_q[i] <= wdata;
    end
    assign flat[i*W +: W] = mem_q[i];
  end

  assign ra_data = mem_q[ra_addr];
  assign rb_data = mem_q[rb_addr];
  assign rd_data = mem_q[rd_addr];

  // R9: a write is present in the array right after its edge
  p_write_lands_r9: assert property (@(posedge clk) disable iff (rst)
    we |=> (mem_q[$past(waddr)] == $past(wdata)));

  // R8: without a write enable nothing in the array moves
  p_idle_hold_r8: assert property (@(posedge clk) disable iff (rst)
    !we |=> $stable(flat));
endmodule

// File: rtl/opunit_alu.sv
module opunit_alu
  import opunit_pkg::*;
#(
  parameter int W = DATA_W
)(
  input  alu_op_e      op,
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  output logic [W-1:0] y,
  output cc_t          cc
);
  always_comb begin
    unique case (op)
      ALU_ADD: y = a + b;
      ALU_AND: y = a & b;
      ALU_NOT: y = ~a;
      default: y = a;
    endcase
  end

  always_comb begin
    cc.neg  = y[W-1];
    cc.zero = (y == '0);
    cc.pos  = ~y[W-1] & (y != '0);
  end
endmodule

// File: rtl/opunit_top.sv
module opunit_top
  import opunit_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              instr_valid,
  output logic              instr_ready,
  input  logic [15:0]       instr_word,
  input  logic [REG_AW-1:0] dbg_sel,
  output logic [DATA_W-1:0] dbg_data,
  output logic [2:0]        cc_flags
);
  dec_t              dec;
  logic [DATA_W-1:0] src1_val, src2_val, opnd_b, alu_y;
  cc_t               alu_cc, cc_q;
  logic              accept;

  assign instr_ready = ~rst;

  opunit_decode u_dec (
    .word  (instr_word),
    .valid (instr_valid & instr_ready),
    .dec   (dec)
  );

  assign accept = dec.legal;

  opunit_regfile #(.W(DATA_W), .N(NREG)) u_rf (
    .clk     (clk),
    .rst     (rst),
    .ra_addr (dec.src1),
    .ra_data (src1_val),
    .rb_addr (dec.src2),
    .rb_data (src2_val),
    .rd_addr (dbg_sel),
    .rd_data (dbg_data),
    .we      (accept),
    .waddr   (dec.dst),
    .wdata   (alu_y)
  );

  assign opnd_b = dec.use_imm ? dec.imm : src2_val;

  opunit_alu #(.W(DATA_W)) u_alu (
    .op (dec.op),
    .a  (src1_val),
    .b  (opnd_b),
    .y  (alu_y),
    .cc (alu_cc)
  );

  always_ff @(posedge clk) begin
    if (rst)         cc_q <= '{neg: 1'b0, zero: 1'b1, pos: 1'b0};
    else if (accept) cc_q <= alu_cc;
  end

  assign cc_flags = cc_q;

  // R6: flags stay one-hot
  p_cc_onehot_r6: assert property (@(posedge clk) disable iff (rst)
    $onehot(cc_q));

  // R6: zero flag tracks the value just written
  p_cc_zero_r6: assert property (@(posedge clk) disable iff (rst)
    accept |=> (cc_q.zero == ($past(alu_y) == '0)));

  // R7: flags frozen when no write is taken
  p_cc_hold_r7: assert property (@(posedge clk) disable iff (rst)
    !accept |=> $stable(cc_q));

  // R10: no acceptance during reset
  p_ready_low_r10: assert property (@(posedge clk)
    rst |-> !instr_ready);
endmodule

// File: tb/sim_opunit_top.sv
module sim_opunit_top;
  logic        clk = 1'b0;
  logic        rst;
  logic        instr_valid;
  logic        instr_ready;
  logic [15:0] instr_word;
  logic [2:0]  dbg_sel;
  logic [15:0] dbg_data;
  logic [2:0]  cc_flags;

  int n_checks = 0;
  int n_fails  = 0;
  logic [15:0] m_reg [8];
  logic [2:0]  m_cc;

  always #10 clk = ~clk;

  opunit_top u0 (
    .clk(clk), .rst(rst), .instr_valid(instr_valid), .instr_ready(instr_ready),
    .instr_word(instr_word), .dbg_sel(dbg_sel), .dbg_data(dbg_data),
    .cc_flags(cc_flags)
  );

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_checks++; n_fails++;
    $display("FAIL watchdog: run did not finish (actual hung, expected done)");
    finish_run();
  end

  task automatic chk(string tag, logic [15:0] act, logic [15:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic logic [15:0] sx5(logic [4:0] v);
    return {{11{v[4]}}, v};
  endfunction

  function automatic logic [2:0] flags_of(logic [15:0] v);
    if (v[15])       return 3'b100;
    else if (v == 0) return 3'b010;
    else             return 3'b001;
  endfunction

  function automatic string tag_of(logic [15:0] w, logic v);
    if (!v) return "R8";
    case (w[15:12])
      4'b0001: return w[5] ? "R3" : "R2";
      4'b0101: return "R4";
      4'b1001: return (w[5:0] == 6'h3F) ? "R5" : "R7";
      default: return "R7";
    endcase
  endfunction

  function automatic logic [15:0] enc(logic [3:0] op, int d, int s1, logic m, logic [4:0] t);
    return {op, d[2:0], s1[2:0], m, t};
  endfunction

  task automatic model(logic [15:0] w, logic v);
    logic [15:0] a, b, r;
    logic ok;
    a = m_reg[w[8:6]];
    b = w[5] ? sx5(w[4:0]) : m_reg[w[2:0]];
    ok = v;
    case (w[15:12])
      4'b0001: r = a + b;
      4'b0101: r = a & b;
      4'b1001: begin r = ~a; if (w[5:0] != 6'h3F) ok = 1'b0; end
      default: begin r = '0; ok = 1'b0; end
    endcase
    if (ok) begin
      m_reg[w[11:9]] = r;
      m_cc = flags_of(r);
    end
  endtask

  task automatic check_all(string tag);
    for (int i = 0; i < 8; i++) begin
      dbg_sel = i[2:0];
      #1;
      chk(tag, dbg_data, m_reg[i]);
    end
    chk({tag, "/R6 flags"}, {13'd0, cc_flags}, {13'd0, m_cc});
  endtask

  task automatic step(logic [15:0] w, logic v);
    @(negedge clk);
    instr_word  = w;
    instr_valid = v;
    @(posedge clk);
    model(w, v);
    #1;
    instr_valid = 1'b0;
    check_all({tag_of(w, v), "/R9"});
  endtask

  initial begin
    void'($urandom(32'd20240611));
    rst = 1'b1; instr_valid = 1'b0; instr_word = '0; dbg_sel = '0;
    for (int i = 0; i < 8; i++) m_reg[i] = '0;
    m_cc = 3'b010;
    // offered during reset, must be dropped
    @(negedge clk); instr_valid = 1'b1; instr_word = enc(4'b0001, 1, 1, 1'b1, 5'd7);
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R10 ready in reset", {15'd0, instr_ready}, 16'd0);
    rst = 1'b0; instr_valid = 1'b0;
    @(negedge clk);
    chk("R10 ready after reset", {15'd0, instr_ready}, 16'd1);
    check_all("R1");

    // build 16'h8000 in R1 by doubling, then 16'h7FFF in R2
    step(enc(4'b0001, 1, 1, 1'b1, 5'd1), 1'b1);
    for (int k = 0; k < 15; k++) step(enc(4'b0001, 1, 1, 1'b0, 5'd1), 1'b1);
    chk("R2 doubled to sign bit", m_reg[1], 16'h8000);
    step(enc(4'b1001, 2, 1, 1'b1, 5'h1F), 1'b1);
    // 0x7FFF + 1 wraps to negative
    step(enc(4'b0001, 3, 2, 1'b1, 5'd1), 1'b1);
    chk("R3 wrap result", m_reg[3], 16'h8000);
    chk("R6 neg on wrap", {13'd0, m_cc}, 16'd4);
    // 0x8000 + 0x8000 -> zero
    step(enc(4'b0001, 4, 1, 1'b0, 5'd1), 1'b1);
    // most negative constant
    step(enc(4'b0001, 5, 0, 1'b1, 5'h10), 1'b1);
    chk("R3 sext -16", m_reg[5], 16'hFFF0);
    // and with constant, and register mode
    step(enc(4'b0101, 6, 2, 1'b1, 5'h0F), 1'b1);
    step(enc(4'b0101, 6, 6, 1'b0, 5'd3), 1'b1);
    // complement in place
    step(enc(4'b1001, 2, 2, 1'b1, 5'h1F), 1'b1);
    chk("R5 in-place complement", m_reg[2], 16'h8000);
    // malformed complement, unknown opcode, idle cycle
    step(enc(4'b1001, 0, 2, 1'b1, 5'h1E), 1'b1);
    step(enc(4'b0011, 0, 2, 1'b1, 5'h1F), 1'b1);
    step(enc(4'b0001, 0, 2, 1'b1, 5'd5), 1'b0);
    chk("R7/R8 R0 untouched", m_reg[0], 16'h0000);

    // seeded random mix
    for (int n = 0; n < 600; n++) begin
      logic [15:0] w;
      int pick;
      w = $urandom();
      pick = $urandom_range(0, 9);
      if (pick < 3)       w[15:12] = 4'b0001;
      else if (pick < 6)  w[15:12] = 4'b0101;
      else if (pick < 9) begin
        w[15:12] = 4'b1001;
        if ($urandom_range(0, 4) != 0) w[5:0] = 6'h3F;
      end
      step(w, $urandom_range(0, 7) != 0);
    end
    finish_run();
  end
endmodule